// File: doc/BRIEF.md
# Ethernet Receive Destination Filter

This block sits beside a receive MAC and decides, once per frame, whether the frame should be kept. It watches the first six bytes of the frame on a byte-wide stream, forms the 48-bit destination address, and runs a bit-reflected CRC-32 over those bytes, one byte per clock, while they arrive. In the cycle after the sixth byte it raises a one-cycle decision strobe with an accept flag.

The decision comes from one of three table formats, plus two override modes. An exact-match format holds sixteen addresses. A 512-bin hash format is indexed by the low nine bits of the CRC and keeps one exact station entry. A 64-bin hash format stores two 32-bit words and can use either of two index rules. All-multicast mode accepts every group-addressed frame. Promiscuous mode accepts everything.

The tables come from a 48-longword setup image written in as 32-bit words, with a format code given at the start of the load. The image fills a shadow copy. The shadow is moved into the active copy only when no frame is being filtered, so a frame always sees one consistent table.

Top module: `rx_addr_filter`

## Requirements
- R1: After reset, and until a setup image takes effect, the active table is the exact format with every entry equal to the all-ones broadcast address. Only broadcast frames are accepted, and `decide_valid` is low after reset.
- R2: A frame starts with a byte that has `rx_sof` and `rx_valid` both high. Its first six valid bytes are the destination, with the first byte in bits 7:0. `decide_valid` is high for exactly one cycle: the cycle after the sixth byte is taken. Bytes after the sixth and before the next start produce no strobe. A new start before six bytes restarts the frame.
- R3: Exact format (code 00). Entry k (0 to 15) is built from longwords 3k, 3k+1 and 3k+2, lowest address halfword first. In each halfword the earlier byte is in bits 7:0. Only bits 15:0 of each longword are used. A frame is accepted if its destination equals any entry.
- R4: 512-bin hash format (code 01). The CRC is the reflected CRC-32: polynomial 0xEDB88320, start value all ones, each byte processed least significant bit first, no final inversion. Its bits 8:0 give a bin n. Bin n is bit n%16 of the low half of longword n/16, for longwords 0 to 31. A set bin accepts the frame.
- R5: When a 512-bin image takes effect, bin 255 (the bin of the broadcast address) is forced set, so broadcast frames are accepted in that format.
- R6: In both hash formats, longwords 39, 40 and 41 hold one station address, laid out as in R3, and a frame whose destination equals it is accepted.
- R7: 64-bin hash format (codes 10 and 11). Longword 0 (all 32 bits) holds bins 0 to 31 and longword 1 holds bins 32 to 63. With `bin64_rule` low, the bin is bits 31:26 of the non-reflected CRC-32 (polynomial 0x04C11DB7, start all ones, data bits least significant first, register shifted toward bit 31). With `bin64_rule` high, the bin is bits 5:0 of the reflected CRC of R4. Bin bit 5 selects the longword and bits 4:0 select the bit.
- R8: With `allmulti_en` high, a frame whose first destination byte has bit 0 set is accepted, whatever the tables hold. Other frames are still decided by the table.
- R9: With `promisc_en` high, every frame is accepted.
- R10: A setup image takes effect only after all 48 longwords have been written. It takes effect only while no frame is between its start byte and its decision. A frame already in progress is decided with the earlier table. A new `setup_start` discards a partial load and restarts the word count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_sof | input | 1 | Marks the first byte of a frame (with rx_valid) |
| rx_valid | input | 1 | rx_byte carries a frame byte |
| rx_byte | input | 8 | Received frame byte |
| promisc_en | input | 1 | Accept every frame |
| allmulti_en | input | 1 | Accept every group-addressed frame |
| bin64_rule | input | 1 | 64-bin index rule: 0 non-reflected top bits, 1 reflected low bits |
| setup_start | input | 1 | Begins a new setup image load |
| setup_fmt | input | 2 | Image format code, sampled with setup_start |
| setup_valid | input | 1 | setup_word carries the next image longword |
| setup_word | input | 32 | Setup image longword |
| decide_valid | output | 1 | One-cycle decision strobe |
| decide_accept | output | 1 | Accept flag, meaningful while decide_valid is high |

## Verification
The assertions assume that `rx_sof` is only raised together with `rx_valid`. They also assume that `promisc_en`, `allmulti_en` and `bin64_rule` hold steady from a frame's sixth byte through its decision cycle, and that `setup_valid` is never high in the same cycle as `setup_start`. The bench changes mode inputs only between frames. It drives setup words only in the cycles after the start pulse. It raises the start flag only on the byte that opens a frame. The one place it deliberately holds a frame open across a whole image load is the test of R10.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
    localparam int ADDR_BYTES      = 6;
    localparam int MAC_W           = ADDR_BYTES * 8;
    localparam int HALF_W          = 16;
    localparam int WORD_W          = 2 * HALF_W;
    localparam int IMG_WORDS       = 48;
    localparam int IMG_W           = IMG_WORDS * HALF_W;
    localparam int WORDS_PER_ENTRY = MAC_W / HALF_W;
    localparam int EXACT_N         = IMG_WORDS / WORDS_PER_ENTRY;
    localparam int STATION_WORD    = 39;
    localparam int HASH_IDX_W      = 9;
    localparam int BIN64_IDX_W     = 6;
    localparam int CRC_W           = 32;
    localparam logic [CRC_W-1:0] CRC_POLY_REFL = 32'hEDB88320;
    localparam int BCAST_BIN       = 255;
    localparam int WCNT_W          = $clog2(IMG_WORDS);
    localparam int BCNT_W          = $clog2(ADDR_BYTES + 1);
    localparam int WIDE_WORDS      = 2;

    typedef enum logic [1:0] {
        FMT_EXACT   = 2'b00,
        FMT_HASH512 = 2'b01,
        FMT_HASH64  = 2'b10
    } img_fmt_e;

    function automatic img_fmt_e fmt_decode(input logic [1:0] code);
        if (code[1])      return FMT_HASH64;
        else if (code[0]) return FMT_HASH512;
        else              return FMT_EXACT;
    endfunction
endpackage

// File: rtl/rxf_crc8.sv
module rxf_crc8 #(
    parameter int                CRC_W  = 32,
    parameter int                DATA_W = 8,
    parameter logic [CRC_W-1:0]  POLY   = 32'hEDB88320
) (
    input  logic [CRC_W-1:0]  crc_in,
    input  logic [DATA_W-1:0] data_in,
    output logic [CRC_W-1:0]  crc_out
);
    logic [DATA_W:0][CRC_W-1:0] stage;

    assign stage[0] = crc_in;

    for (genvar b = 0; b < DATA_W; b++) begin : g_bit
        logic fb;
        assign fb = stage[b][0] ^ data_in[b];
        assign stage[b+1] = (stage[b] >> 1) ^ (fb ? POLY : '0);
    end

    assign crc_out = stage[DATA_W];
endmodule

// File: rtl/rxf_setup_store.sv
module rxf_setup_store
    import rxf_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 setup_start,
    input  logic [1:0]           setup_fmt,
    input  logic                 setup_valid,
    input  logic [WORD_W-1:0]    setup_word,
    input  logic                 frame_busy,
    output img_fmt_e             act_fmt,
    output logic [IMG_W-1:0]     act_img,
    output logic [WIDE_WORDS*HALF_W-1:0] act_hi
);
    typedef struct packed {
        logic [IMG_W-1:0]               shd_img;
        logic [WIDE_WORDS*HALF_W-1:0]   shd_hi;
        img_fmt_e                       shd_fmt;
        logic [WCNT_W-1:0]              wcnt;
        logic                           loading;
        logic                           pending;
        logic [IMG_W-1:0]               act_img;
        logic [WIDE_WORDS*HALF_W-1:0]   act_hi;
        img_fmt_e                       act_fmt;
    } store_t;

    store_t d, q;

    always_comb begin
        d = q;
        // Swap a complete shadow image in while no frame is open.
        if (q.pending && !frame_busy) begin
            d.act_img = q.shd_img;
            if (q.shd_fmt == FMT_HASH512) d.act_img[BCAST_BIN] = 1'b1;
            d.act_hi  = q.shd_hi;
            d.act_fmt = q.shd_fmt;
            d.pending = 1'b0;
        end
        if (setup_start) begin
            d.shd_fmt = fmt_decode(setup_fmt);
            d.wcnt    = '0;
            d.loading = 1'b1;
            d.pending = 1'b0;
        end else if (q.loading && setup_valid) begin
            d.shd_img[q.wcnt*HALF_W +: HALF_W] = setup_word[HALF_W-1:0];
            if (q.wcnt < WCNT_W'(WIDE_WORDS))
                d.shd_hi[q.wcnt[0]*HALF_W +: HALF_W] = setup_word[WORD_W-1:HALF_W];
            if (q.wcnt == WCNT_W'(IMG_WORDS - 1)) begin
                d.loading = 1'b0;
                d.pending = 1'b1;
                d.wcnt    = '0;
            end else begin
                d.wcnt = q.wcnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.shd_img <= '1;
            q.shd_hi  <= '1;
            q.shd_fmt <= FMT_EXACT;
            q.wcnt    <= '0;
            q.loading <= 1'b0;
            q.pending <= 1'b0;
            q.act_img <= '1;
            q.act_hi  <= '1;
            q.act_fmt <= FMT_EXACT;
        end else begin
            q <= d;
        end
    end

    assign act_fmt = q.act_fmt;
    assign act_img = q.act_img;
    assign act_hi  = q.act_hi;

    // R10: the table a frame is using never changes under it
    assert_stable_active_R10: assert property (@(posedge clk) disable iff (!rst_n)
        frame_busy |=> ($stable(q.act_img) && $stable(q.act_fmt) && $stable(q.act_hi)));

    // R10: the word count stays inside the image while loading
    assert_wcnt_range_R10: assert property (@(posedge clk) disable iff (!rst_n)
        q.loading |-> (q.wcnt < WCNT_W'(IMG_WORDS)));

    // R10: a load in progress and a waiting image never coexist
    assert_load_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(q.loading && q.pending));

    // R5: an active 512-bin table always carries the broadcast bin
    assert_bcast_bin_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (q.act_fmt == FMT_HASH512) |-> q.act_img[BCAST_BIN]);
endmodule

// File: rtl/rxf_match.sv
module rxf_match
    import rxf_pkg::*;
(
    input  logic [MAC_W-1:0]             dst,
    input  logic [HASH_IDX_W-1:0]        crc_low,
    input  img_fmt_e                     act_fmt,
    input  logic [IMG_W-1:0]             act_img,
    input  logic [WIDE_WORDS*HALF_W-1:0] act_hi,
    input  logic                         promisc_en,
    input  logic                         allmulti_en,
    input  logic                         bin64_rule,
    output logic                         accept
);
    logic [EXACT_N-1:0]     entry_hit;
    logic                   station_hit;
    logic [BIN64_IDX_W-1:0] idx_std;
    logic [BIN64_IDX_W-1:0] idx64;
    logic [2*WORD_W-1:0]    bins64;
    logic                   table_hit;

    for (genvar k = 0; k < EXACT_N; k++) begin : g_entry
        assign entry_hit[k] = (act_img[k*WORDS_PER_ENTRY*HALF_W +: MAC_W] == dst);
    end

    assign station_hit = (act_img[STATION_WORD*HALF_W +: MAC_W] == dst);

    // The non-reflected CRC is the bit reversal of the reflected one.
    for (genvar j = 0; j < BIN64_IDX_W; j++) begin : g_rev
        assign idx_std[BIN64_IDX_W-1-j] = crc_low[j];
    end

    assign idx64  = bin64_rule ? crc_low[BIN64_IDX_W-1:0] : idx_std;
    assign bins64 = {act_hi[HALF_W +: HALF_W], act_img[HALF_W +: HALF_W],
                     act_hi[0 +: HALF_W],      act_img[0 +: HALF_W]};

    always_comb begin
        unique case (act_fmt)
            FMT_HASH512: table_hit = act_img[crc_low] | station_hit;
            FMT_HASH64:  table_hit = bins64[idx64] | station_hit;
            default:     table_hit = |entry_hit;
        endcase
    end

    assign accept = promisc_en | (allmulti_en & dst[0]) | table_hit;
endmodule

// File: rtl/rx_addr_filter.sv
module rx_addr_filter
    import rxf_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        rx_sof,
    input  logic        rx_valid,
    input  logic [7:0]  rx_byte,
    input  logic        promisc_en,
    input  logic        allmulti_en,
    input  logic        bin64_rule,
    input  logic        setup_start,
    input  logic [1:0]  setup_fmt,
    input  logic        setup_valid,
    input  logic [31:0] setup_word,
    output logic        decide_valid,
    output logic        decide_accept
);
    typedef struct packed {
        logic              busy;
        logic              done;
        logic [BCNT_W-1:0] cnt;
        logic [CRC_W-1:0]  crc;
        logic [MAC_W-1:0]  dst;
    } frame_t;

    frame_t d, q;

    logic [CRC_W-1:0]             crc_seed;
    logic [CRC_W-1:0]             crc_next;
    img_fmt_e                     act_fmt;
    logic [IMG_W-1:0]             act_img;
    logic [WIDE_WORDS*HALF_W-1:0] act_hi;
    logic                         match_accept;

    assign crc_seed = rx_sof ? '1 : q.crc;

    rxf_crc8 #(.CRC_W(CRC_W), .DATA_W(8), .POLY(CRC_POLY_REFL)) u_crc (
        .crc_in  (crc_seed),
        .data_in (rx_byte),
        .crc_out (crc_next)
    );

    rxf_setup_store u_store (
        .clk         (clk),
        .rst_n       (rst_n),
        .setup_start (setup_start),
        .setup_fmt   (setup_fmt),
        .setup_valid (setup_valid),
        .setup_word  (setup_word),
        .frame_busy  (q.busy),
        .act_fmt     (act_fmt),
        .act_img     (act_img),
        .act_hi      (act_hi)
    );

    rxf_match u_match (
        .dst         (q.dst),
        .crc_low     (q.crc[HASH_IDX_W-1:0]),
        .act_fmt     (act_fmt),
        .act_img     (act_img),
        .act_hi      (act_hi),
        .promisc_en  (promisc_en),
        .allmulti_en (allmulti_en),
        .bin64_rule  (bin64_rule),
        .accept      (match_accept)
    );

    always_comb begin
        d = q;
        if (q.done) begin
            d.done = 1'b0;
            d.busy = 1'b0;
        end
        if (rx_valid && rx_sof) begin
            d.busy     = 1'b1;
            d.cnt      = BCNT_W'(1);
            d.crc      = crc_next;
            d.dst      = '0;
            d.dst[7:0] = rx_byte;
        end else if (rx_valid && q.busy && (q.cnt < BCNT_W'(ADDR_BYTES))) begin
            d.crc              = crc_next;
            d.dst[q.cnt*8 +: 8] = rx_byte;
            d.cnt              = q.cnt + 1'b1;
            if (q.cnt == BCNT_W'(ADDR_BYTES - 1)) d.done = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.busy <= 1'b0;
            q.done <= 1'b0;
            q.cnt  <= '0;
            q.crc  <= '1;
            q.dst  <= '0;
        end else begin
            q <= d;
        end
    end

    assign decide_valid  = q.done;
    assign decide_accept = q.done & match_accept;

    // R2: the decision strobe lasts one cycle
    assert_strobe_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        decide_valid |=> !decide_valid);

    // R2: a strobe follows a taken byte and sits inside an open frame
    assert_strobe_after_byte_R2: assert property (@(posedge clk) disable iff (!rst_n)
        decide_valid |-> ($past(rx_valid) && q.busy));

    // R9: promiscuous decisions always accept
    assert_promisc_accept_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (decide_valid && promisc_en) |-> decide_accept);

    // R8: group-addressed frames pass in all-multicast mode
    assert_allmulti_group_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (decide_valid && allmulti_en && q.dst[0]) |-> decide_accept);

    // R5: broadcast passes whenever a 512-bin table is active
    assert_bcast_hash_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (decide_valid && (act_fmt == FMT_HASH512) && (q.dst == '1)) |-> decide_accept);
endmodule

// File: tb/rx_addr_filter_test.sv
module rx_addr_filter_test;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 10;
    localparam int WATCHDOG_CYCLES = 150000;
    // {promisc, allmulti, destination with first byte in bits 7:0}
    localparam logic [49:0] VEC [NVEC] = '{
        {2'b00, 48'h0605_0403_0200},
        {2'b00, 48'hFFFF_FFFF_FFFF},
        {2'b00, 48'h1A2B_3C4D_5E01},
        {2'b00, 48'h0000_0000_0000},
        {2'b00, 48'hDEAD_BEEF_0042},
        {2'b01, 48'h0102_0304_0533},
        {2'b01, 48'h9988_7766_5544},
        {2'b10, 48'h1234_5678_9ABC},
        {2'b00, 48'h0F0E_0D0C_0B0A},
        {2'b00, 48'h7654_3210_FEDC}
    };

    logic clk = 1'b0, rst_n = 1'b0;
    logic rx_sof = 1'b0, rx_valid = 1'b0;
    logic [7:0] rx_byte = '0;
    logic promisc_en = 1'b0, allmulti_en = 1'b0, bin64_rule = 1'b0;
    logic setup_start = 1'b0, setup_valid = 1'b0;
    logic [1:0] setup_fmt = '0;
    logic [31:0] setup_word = '0;
    logic decide_valid, decide_accept;

    int checks = 0, fails = 0;
    logic [15:0] m_lo [48];
    logic [15:0] m_hi [2];
    int m_fmt;
    logic [15:0] n_lo [48];
    logic [15:0] n_hi [2];
    int n_fmt;

    rx_addr_filter uut (
        .clk(clk), .rst_n(rst_n), .rx_sof(rx_sof), .rx_valid(rx_valid), .rx_byte(rx_byte),
        .promisc_en(promisc_en), .allmulti_en(allmulti_en), .bin64_rule(bin64_rule),
        .setup_start(setup_start), .setup_fmt(setup_fmt), .setup_valid(setup_valid),
        .setup_word(setup_word), .decide_valid(decide_valid), .decide_accept(decide_accept)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [31:0] crc_refl(input logic [47:0] a);
        logic [31:0] c = 32'hFFFF_FFFF;
        for (int i = 0; i < 48; i++) begin
            logic fb = c[0] ^ a[i];
            c = c >> 1;
            if (fb) c = c ^ 32'hEDB8_8320;
        end
        return c;
    endfunction

    function automatic logic [31:0] crc_std(input logic [47:0] a);
        logic [31:0] c = 32'hFFFF_FFFF;
        for (int i = 0; i < 48; i++) begin
            logic fb = c[31] ^ a[i];
            c = c << 1;
            if (fb) c = c ^ 32'h04C1_1DB7;
        end
        return c;
    endfunction

    function automatic logic model(input logic [47:0] a, input logic pr, input logic am,
                                   input logic rule);
        logic [31:0] r, s;
        logic [63:0] t;
        int idx;
        logic hit;
        hit = 1'b0;
        if (pr) return 1'b1;
        if (am && a[0]) return 1'b1;
        r = crc_refl(a);
        s = crc_std(a);
        if (m_fmt == 0) begin
            for (int k = 0; k < 16; k++)
                if ({m_lo[3*k+2], m_lo[3*k+1], m_lo[3*k]} == a) hit = 1'b1;
        end else begin
            if ({m_lo[41], m_lo[40], m_lo[39]} == a) hit = 1'b1;
            if (m_fmt == 1) begin
                idx = int'(r[8:0]);
                if (m_lo[idx/16][idx%16] || idx == 255) hit = 1'b1;
            end else begin
                idx = rule ? int'(r[5:0]) : int'(s[31:26]);
                t = {m_hi[1], m_lo[1], m_hi[0], m_lo[0]};
                if (t[idx]) hit = 1'b1;
            end
        end
        return hit;
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic put_byte(input logic [47:0] a, input int i);
        @(negedge clk);
        rx_valid = 1'b1;
        rx_sof   = (i == 0);
        rx_byte  = a[8*i +: 8];
    endtask

    task automatic finish_frame(output logic v, output logic acc);
        @(negedge clk);
        rx_valid = 1'b0;
        rx_sof   = 1'b0;
        v   = decide_valid;
        acc = decide_accept;
        @(negedge clk);
    endtask

    task automatic frame(input logic [47:0] a, output logic v, output logic acc);
        for (int i = 0; i < 6; i++) put_byte(a, i);
        finish_frame(v, acc);
    endtask

    task automatic img_clear(input logic [15:0] fill);
        for (int w = 0; w < 48; w++) n_lo[w] = fill;
        n_hi[0] = '0;
        n_hi[1] = '0;
    endtask

    task automatic img_entry(input int k, input logic [47:0] a);
        n_lo[3*k]   = a[15:0];
        n_lo[3*k+1] = a[31:16];
        n_lo[3*k+2] = a[47:32];
    endtask

    task automatic img_bin512(input logic [47:0] a);
        logic [31:0] r;
        r = crc_refl(a);
        n_lo[r[8:4]][r[3:0]] = 1'b1;
    endtask

    task automatic img_bin64(input logic [5:0] idx);
        logic [31:0] w;
        w = {n_hi[idx[5]], n_lo[idx[5]]};
        w[idx[4:0]] = 1'b1;
        n_hi[idx[5]] = w[31:16];
        n_lo[idx[5]] = w[15:0];
    endtask

    task automatic load_img(input int fmt, input int nwords);
        @(negedge clk);
        setup_start = 1'b1;
        setup_fmt   = 2'(fmt);
        @(negedge clk);
        setup_start = 1'b0;
        for (int w = 0; w < nwords; w++) begin
            setup_valid = 1'b1;
            setup_word[15:0]  = n_lo[w];
            setup_word[31:16] = (fmt == 2 && w < 2) ? n_hi[w] : (16'(w) * 16'h2F1B) ^ 16'hC35A;
            @(negedge clk);
        end
        setup_valid = 1'b0;
    endtask

    task automatic commit();
        m_lo  = n_lo;
        m_hi  = n_hi;
        m_fmt = n_fmt;
    endtask

    task automatic run_vectors(input string tag);
        logic v, acc, e;
        for (int i = 0; i < NVEC; i++) begin
            promisc_en  = VEC[i][49];
            allmulti_en = VEC[i][48];
            e = model(VEC[i][47:0], VEC[i][49], VEC[i][48], bin64_rule);
            frame(VEC[i][47:0], v, acc);
            chk(VEC[i][49] ? "R9" : (VEC[i][48] ? "R8" : tag), {v, acc}, {1'b1, e});
        end
        promisc_en  = 1'b0;
        allmulti_en = 1'b0;
    endtask

    initial begin
        repeat (WATCHDOG_CYCLES) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic v, acc;
        img_clear(16'hFFFF);
        n_fmt = 0;
        commit();

        // R1: reset state
        repeat (3) @(negedge clk);
        chk("R1", {decide_valid, decide_accept}, 2'b00);
        rst_n = 1'b1;
        @(negedge clk);
        frame(48'hFFFF_FFFF_FFFF, v, acc);
        chk("R1", {v, acc}, 2'b11);
        frame(48'h0, v, acc);
        chk("R1", {v, acc}, 2'b10);
        frame(VEC[4][47:0], v, acc);
        chk("R1", {v, acc}, 2'b10);

        // R2: strobe timing, trailing bytes, restart
        for (int i = 0; i < 6; i++) begin
            put_byte(VEC[1][47:0], i);
            if (i > 0) chk("R2", decide_valid, 1'b0);
        end
        @(negedge clk);
        rx_valid = 1'b0;
        chk("R2", decide_valid, 1'b1);
        @(negedge clk);
        chk("R2", decide_valid, 1'b0);
        for (int i = 0; i < 3; i++) begin
            put_byte(VEC[1][47:0], 1);
            chk("R2", decide_valid, 1'b0);
        end
        @(negedge clk);
        rx_valid = 1'b0;
        chk("R2", decide_valid, 1'b0);
        for (int i = 0; i < 3; i++) put_byte(48'h0, i);
        frame(48'hFFFF_FFFF_FFFF, v, acc);
        chk("R2", {v, acc}, 2'b11);

        // R3: exact format with garbage upper halves
        img_clear(16'hFFFF);
        img_entry(0, VEC[0][47:0]);
        img_entry(1, VEC[2][47:0]);
        img_entry(2, VEC[4][47:0]);
        img_entry(3, VEC[6][47:0]);
        img_entry(15, VEC[8][47:0]);
        n_fmt = 0;
        load_img(0, 48);
        commit();
        run_vectors("R3");

        // R4: 512-bin hash format
        img_clear(16'h0000);
        img_bin512(VEC[0][47:0]);
        img_bin512(VEC[2][47:0]);
        img_entry(13, VEC[8][47:0]);
        n_fmt = 1;
        load_img(1, 48);
        commit();
        run_vectors("R4");

        // R5, R6: empty bins, broadcast forced, station entry
        img_clear(16'h0000);
        img_entry(13, VEC[8][47:0]);
        n_fmt = 1;
        load_img(1, 48);
        commit();
        frame(48'hFFFF_FFFF_FFFF, v, acc);
        chk("R5", {v, acc}, 2'b11);
        frame(VEC[8][47:0], v, acc);
        chk("R6", {v, acc}, 2'b11);
        frame(VEC[9][47:0], v, acc);
        chk("R6", {v, acc}, {1'b1, model(VEC[9][47:0], 1'b0, 1'b0, 1'b0)});

        // R7: 64-bin hash, both index rules
        begin
            logic [31:0] s, r;
            img_clear(16'h0000);
            s = crc_std(VEC[0][47:0]);
            img_bin64(s[31:26]);
            r = crc_refl(VEC[4][47:0]);
            img_bin64(r[5:0]);
            img_entry(13, VEC[8][47:0]);
            n_fmt = 2;
        end
        load_img(2, 48);
        commit();
        bin64_rule = 1'b0;
        run_vectors("R7");
        bin64_rule = 1'b1;
        run_vectors("R7");
        bin64_rule = 1'b0;

        // R10: swap deferred until a frame completes
        img_clear(16'hFFFF);
        img_entry(0, VEC[0][47:0]);
        n_fmt = 0;
        load_img(0, 48);
        commit();
        img_clear(16'hFFFF);
        img_entry(0, VEC[9][47:0]);
        n_fmt = 0;
        for (int i = 0; i < 3; i++) put_byte(VEC[0][47:0], i);
        @(negedge clk);
        rx_valid = 1'b0;
        rx_sof   = 1'b0;
        load_img(0, 48);
        for (int i = 3; i < 6; i++) put_byte(VEC[0][47:0], i);
        finish_frame(v, acc);
        chk("R10", {v, acc}, 2'b11);
        commit();
        frame(VEC[0][47:0], v, acc);
        chk("R10", {v, acc}, 2'b10);
        frame(VEC[9][47:0], v, acc);
        chk("R10", {v, acc}, 2'b11);

        // R10: partial load has no effect; a restart loads cleanly
        img_clear(16'hFFFF);
        img_entry(0, VEC[0][47:0]);
        load_img(0, 20);
        frame(VEC[0][47:0], v, acc);
        chk("R10", {v, acc}, 2'b10);
        frame(VEC[9][47:0], v, acc);
        chk("R10", {v, acc}, 2'b11);
        load_img(0, 48);
        commit();
        frame(VEC[0][47:0], v, acc);
        chk("R10", {v, acc}, 2'b11);
        frame(VEC[9][47:0], v, acc);
        chk("R10", {v, acc}, 2'b10);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule